// File: doc/BRIEF.md
# Receiver Reset Sequencer

This block orders the reset of a serial receiver datapath. It runs on a slow internal clock of about 50 MHz. A reset sequence has two timed phases: a settle (wait) phase and a reset-in-progress phase. During the whole sequence, one reset output holds the entire receiver in reset. When the sequencer returns to idle, it raises a completion flag. The default phase lengths are 2000 and 4000 cycles, about 120 µs in total.

Three events start a sequence:
- the release of the chip-level active-low reset;
- the PLL power-down input dropping from high to low;
- a pulse on an asynchronous receiver reset input.

The asynchronous pulse is captured by a set-dominant flop, so a pulse shorter than a clock period is not lost. A two-flop synchronizer then passes it to the FSM. A trigger that arrives while a sequence is running restarts the sequence from the wait phase.

Top module: `rx_rst_seq`

## Requirements
- R1: While `rst_ni` is low, `rx_rst_o` is 1 and `rst_done_o` is 0. This takes effect without waiting for a clock edge.
- R2: After `rst_ni` rises, with no other trigger, `rst_done_o` stays 0 for the first WAIT_CYCLES+RUN_CYCLES-1 rising clock edges and is 1 after edge WAIT_CYCLES+RUN_CYCLES.
- R3: `rx_rst_o` is always the inverse of `rst_done_o`.
- R4: Whenever `pll_pd_i` (synchronous to `clk_i`) is sampled high at a clock edge, `rx_rst_o` is 1 and `rst_done_o` is 0 after that edge.
- R5: After `pll_pd_i` is last sampled high, `rst_done_o` rises after exactly WAIT_CYCLES+RUN_CYCLES further edges and not earlier.
- R6: A high pulse on `rx_rst_i` shorter than one clock period starts a sequence, counting clock edges from the pulse with two synchronizer stages:
  - `rst_done_o` is 0 after the third edge;
  - `rst_done_o` is still 0 after edge 4+WAIT_CYCLES+RUN_CYCLES;
  - `rst_done_o` is 1 after edge 5+WAIT_CYCLES+RUN_CYCLES.
- R7: A trigger that arrives in any cycle of a running sequence restarts the full WAIT_CYCLES+RUN_CYCLES count from that trigger.
- R8: With no trigger, an idle sequencer stays idle: `rst_done_o` remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow internal sequencer clock |
| rst_ni | input | 1 | Chip-level active-low asynchronous reset; its release starts a sequence |
| pll_pd_i | input | 1 | PLL power-down, synchronous; high holds the sequencer, a fall starts a sequence |
| rx_rst_i | input | 1 | Asynchronous receiver reset pulse |
| rx_rst_o | output | 1 | Reset for the entire receiver, high during a sequence |
| rst_done_o | output | 1 | High once a sequence has completed and the sequencer is idle |

## Verification
Each result has a fixed due cycle:
- After a reset release or a power-down fall, completion is due exactly WAIT_CYCLES+RUN_CYCLES rising edges later.
- After an asynchronous pulse, completion is due five edges further than that; the loss of completion is due by the third edge.
- After a power-down sample, the hold is due one edge later.

Inputs are driven on the falling edge and both outputs are sampled on the following falling edge, so the bench counts every edge in between. For each restart it checks that completion is still low one edge before the due edge and high on the due edge itself.

// File: rtl/rx_rst_pkg.sv
`timescale 1ns/1ps
package rx_rst_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

  function automatic int unsigned max_cnt(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rx_rst_pulse_sync.sv
`timescale 1ns/1ps
// Catches an asynchronous pulse of any width and delivers a level into clk_i domain.
module rx_rst_pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic level_o
);

  logic              cap_q;
  logic [STAGES-1:0] chain_q;

  // set-dominant capture; cleared once the synchronized copy is seen
  always_ff @(posedge clk_i or negedge rst_ni or posedge pulse_i) begin
    if (!rst_ni)                cap_q <= 1'b0;
    else if (pulse_i)           cap_q <= 1'b1;
    else if (chain_q[STAGES-1]) cap_q <= 1'b0;
  end

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= cap_q;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], cap_q};
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/rx_rst_fsm.sv
`timescale 1ns/1ps
module rx_rst_fsm
  import rx_rst_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 2000,
  parameter int unsigned RUN_CYCLES  = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic rst_o,
  output logic done_o
);

  localparam int unsigned CNT_MAX = max_cnt(max_cnt(WAIT_CYCLES, RUN_CYCLES), 2);
  localparam int unsigned CW      = $clog2(CNT_MAX);
  localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_CYCLES - 1);
  localparam logic [CW-1:0] RUN_LAST  = CW'(RUN_CYCLES - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (state_q)
      SEQ_IDLE: cnt_d = '0;
      SEQ_WAIT: if (cnt_q == WAIT_LAST) begin
        state_d = SEQ_RUN;
        cnt_d   = '0;
      end
      SEQ_RUN: if (cnt_q == RUN_LAST) begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
      default: begin
        state_d = SEQ_WAIT;
        cnt_d   = '0;
      end
    endcase
    // any trigger or power-down restarts from the first wait cycle
    if (hold_i) begin
      state_d = SEQ_WAIT;
      cnt_d   = '0;
    end
  end

  // reset value is the start of a sequence: release begins counting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_WAIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rst_o  = (state_q != SEQ_IDLE);
  assign done_o = (state_q == SEQ_IDLE);

endmodule

// File: rtl/rx_rst_seq.sv
`timescale 1ns/1ps
module rx_rst_seq #(
  parameter int unsigned WAIT_CYCLES = 2000,
  parameter int unsigned RUN_CYCLES  = 4000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_pd_i,
  input  logic rx_rst_i,
  output logic rx_rst_o,
  output logic rst_done_o
);

  logic rx_rst_sync;
  logic seq_hold;

  rx_rst_pulse_sync #(
    .STAGES (SYNC_STAGES)
  ) i_pulse_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (rx_rst_i),
    .level_o (rx_rst_sync)
  );

  // a level hold covers both the power-down high time and its falling edge
  assign seq_hold = pll_pd_i | rx_rst_sync;

  rx_rst_fsm #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .RUN_CYCLES  (RUN_CYCLES)
  ) i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (seq_hold),
    .rst_o  (rx_rst_o),
    .done_o (rst_done_o)
  );

endmodule

// File: rtl/rx_rst_seq_chk.sv
`timescale 1ns/1ps
module rx_rst_seq_chk #(
  parameter int unsigned WAIT_CYCLES = 2000,
  parameter int unsigned RUN_CYCLES  = 4000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pll_pd_i,
  input logic hold_i,
  input logic rx_rst_o,
  input logic rst_done_o
);

  localparam int unsigned TOTAL = WAIT_CYCLES + RUN_CYCLES;
  localparam int unsigned CW    = $clog2(TOTAL + 2);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (hold_i)   run_q <= '0;
    else if (rx_rst_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  a_r3_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_o != rst_done_o);

  a_r4_pd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_pd_i |=> (rx_rst_o && !rst_done_o));

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !rst_done_o);

  a_r2_full_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_done_o) |-> (run_q == CW'(TOTAL)));

  a_r8_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_done_o && !hold_i) |=> rst_done_o);

endmodule

bind rx_rst_seq rx_rst_seq_chk #(
  .WAIT_CYCLES (WAIT_CYCLES),
  .RUN_CYCLES  (RUN_CYCLES)
) i_rx_rst_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pll_pd_i   (pll_pd_i),
  .hold_i     (seq_hold),
  .rx_rst_o   (rx_rst_o),
  .rst_done_o (rst_done_o)
);

// File: tb/test_rx_rst_seq.sv
`timescale 1ns/1ps
module test_rx_rst_seq;

  localparam int unsigned W   = 5;
  localparam int unsigned R   = 7;
  localparam int unsigned TOT = W + R;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pll_pd_i = 1'b0;
  logic rx_rst_i = 1'b0;
  logic rx_rst_o;
  logic rst_done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  rx_rst_seq #(
    .WAIT_CYCLES (W),
    .RUN_CYCLES  (R),
    .SYNC_STAGES (2)
  ) i_rx_rst_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pll_pd_i   (pll_pd_i),
    .rx_rst_i   (rx_rst_i),
    .rx_rst_o   (rx_rst_o),
    .rst_done_o (rst_done_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // counts TOT edges from the current point; completion due on the last
  task automatic run_full(input string req);
    for (int k = 1; k <= TOT; k++) begin
      step();
      chk(req, rst_done_o, (k == TOT));
      chk("R3", rx_rst_o, (k != TOT));
    end
  endtask

  task automatic pd_pulse(input int n);
    pll_pd_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      step();
      chk("R4", rst_done_o, 1'b0);
      chk("R4", rx_rst_o, 1'b1);
    end
    pll_pd_i = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) step();
    chk("R1", rx_rst_o, 1'b1);
    chk("R1", rst_done_o, 1'b0);

    // R2 release starts a sequence
    rst_ni = 1'b1;
    run_full("R2");

    // R8 idle stays idle
    for (int i = 0; i < 20; i++) begin
      step();
      chk("R8", rst_done_o, 1'b1);
    end

    // R4/R5 power-down held for several lengths
    for (int h = 1; h <= 4; h++) begin
      pd_pulse(h);
      run_full("R5");
    end

    // R7 restart by power-down at every offset of a running sequence
    for (int off = 1; off < TOT; off++) begin
      pd_pulse(1);
      for (int k = 1; k <= off; k++) begin
        step();
        chk("R7", rst_done_o, 1'b0);
      end
      pd_pulse(1);
      run_full("R7");
    end

    // R6 short asynchronous pulse, several widths
    for (int w = 1; w <= 3; w++) begin
      #0.5 rx_rst_i = 1'b1;
      #(0.4 * w) rx_rst_i = 1'b0;
      for (int e = 1; e <= 5 + TOT; e++) begin
        @(posedge clk_i);
        @(negedge clk_i);
        if (e == 3) chk("R6", rst_done_o, 1'b0);
        if (e == 4 + TOT) chk("R6", rst_done_o, 1'b0);
        if (e == 5 + TOT) chk("R6", rst_done_o, 1'b1);
      end
    end

    // R7 asynchronous pulse in the middle of a power-down started sequence
    pd_pulse(1);
    repeat (W) step();
    #0.5 rx_rst_i = 1'b1;
    #0.5 rx_rst_i = 1'b0;
    for (int e = 1; e <= 5 + TOT; e++) begin
      step();
      chk("R7", rst_done_o, (e == 5 + TOT));
    end

    // R1 asynchronous assertion of the chip reset while idle
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1", rx_rst_o, 1'b1);
    chk("R1", rst_done_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_full("R2");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule